// File: doc/BRIEF.md
# Real-time clock seconds counter with alarm and interrupts

The block keeps wall-clock time as a 32-bit count of seconds. It advances on a one-second strobe that an external prescaler supplies. Software reaches it through a simple 32-bit register bus. A request with write enable takes effect on the clock edge. A read is combinational from the addressed word.

A new time is not loaded into the running counter at once. It is held as pending and loaded exactly on the next strobe. Until that strobe, a readback word returns the value written, so software can still report the correct time. A 32-bit alarm is compared against the running count.

Two event sources feed a small interrupt controller. One is the seconds strobe and the other is the alarm match. The controller has write-one-to-clear status, a mask, and separate unmask and mask command words. The block also stores a calibration word and two control bits, the battery switch-over enable at bit 31 and the oscillator enable at bit 24. Nothing inside the block acts on these stored values.

Top module: `rtc_core`

## Requirements
- R1: After reset the running time, the time readback (0x04), the interrupt status (0x20) and irq_o are all zero, and the mask word (0x24) reads 0x3, so both sources are masked.
- R2: A strobe on sec_tick_i with no pending time raises the running time (0x10) by one on that edge, and 0xFFFFFFFF wraps to 0.
- R3: Every strobe sets status bit 0 (the seconds event) on the same edge.
- R4: A write to 0x00 shows up at 0x04 on the next edge. It leaves 0x10 unchanged until the next strobe, which loads the written value exactly, with no increment.
- R5: When a time write and a strobe fall in the same cycle, the strobe acts on the state from before the write. The written value is loaded at the following strobe.
- R6: Status bit 1 (the alarm event) is set one edge after the running time becomes equal to the alarm word (0x18). The match may come from a strobe or from an alarm write. A match that continues sets the bit only once.
- R7: Writing 1 to a bit of 0x20 clears that status bit and writing 0 leaves it. An event that arrives in the same cycle as its clear wins.
- R8: Writing 1 to a bit of 0x28 clears that mask bit (the source is unmasked). Writing 1 to 0x2C sets it. 0x24 reads the mask, and bits above 1 are ignored.
- R9: Status bits set whatever the mask holds. irq_o is high exactly when some status bit is set and its mask bit is clear.
- R10: The control word (0x40) keeps only bits 31 and 24 of a write. All other bits read 0.
- R11: A write to 0x08 stores the low 21 bits as calibration, and 0x0C reads them back. Reads of 0x08, 0x14 and unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-cycle pulse per second from the prescaler |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write enable for the request |
| addr_i | input | ADDR_W (8) | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Register writes, the time load and the seconds status all land on the edge that samples the request or strobe. A read on the following falling edge therefore sees them. The alarm status comes one edge later, because the match is compared against its previous value first. irq_o follows the status and mask flops with no delay. Each bench task drives inputs on a falling edge and releases them on the next one. A read check waits one more falling edge before it samples, so every check lands at least one edge after the result is due.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NSRC   = 2;
  localparam int unsigned SRC_SEC = 0;
  localparam int unsigned SRC_ALM = 1;

  // word indices (byte offset >> 2)
  localparam int unsigned OFS_TSET    = 0;   // 0x00
  localparam int unsigned OFS_TSET_RB = 1;   // 0x04
  localparam int unsigned OFS_CAL_WR  = 2;   // 0x08
  localparam int unsigned OFS_CAL_RD  = 3;   // 0x0C
  localparam int unsigned OFS_TNOW    = 4;   // 0x10
  localparam int unsigned OFS_TICK    = 5;   // 0x14
  localparam int unsigned OFS_ALARM   = 6;   // 0x18
  localparam int unsigned OFS_IST     = 8;   // 0x20
  localparam int unsigned OFS_IMSK    = 9;   // 0x24
  localparam int unsigned OFS_IEN     = 10;  // 0x28
  localparam int unsigned OFS_IDIS    = 11;  // 0x2C
  localparam int unsigned OFS_CTRL    = 16;  // 0x40

  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h8100_0000;
endpackage

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              set_we_i,
  input  logic [TIME_W-1:0] set_val_i,
  output logic [TIME_W-1:0] time_o,
  output logic [TIME_W-1:0] set_rb_o
);
  logic [TIME_W-1:0] cur_q, pend_q, rb_q;
  logic              pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q      <= '0;
      pend_q     <= '0;
      rb_q       <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      if (tick_i) begin
        cur_q      <= pend_vld_q ? pend_q : cur_q + TIME_W'(1);
        pend_vld_q <= 1'b0;
      end
      // a write in the tick cycle pends for the next tick
      if (set_we_i) begin
        pend_q     <= set_val_i;
        rb_q       <= set_val_i;
        pend_vld_q <= 1'b1;
      end
    end
  end

  assign time_o   = cur_q;
  assign set_rb_o = rb_q;

  assert_tick_incr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !pend_vld_q |=> time_o == $past(time_o) + TIME_W'(1));
  assert_tick_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && pend_vld_q |=> time_o == $past(pend_q));
  assert_hold_no_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(time_o));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] alarm_i,
  output logic              evt_o
);
  logic match, match_q;

  assign match = (time_i == alarm_i);

  // reset high: equal reset values must not raise an event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b1;
    else         match_q <= match;
  end

  assign evt_o = match & ~match_q;

  assert_single_evt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic            clr_we_i,
  input  logic            en_we_i,
  input  logic            dis_we_i,
  input  logic [NSRC-1:0] bits_i,
  output logic [NSRC-1:0] sts_o,
  output logic [NSRC-1:0] mask_o,
  output logic            irq_o
);
  logic [NSRC-1:0] sts_q, mask_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sts_q[i]  <= 1'b0;
        mask_q[i] <= 1'b1;
      end else begin
        sts_q[i] <= set_i[i] | (sts_q[i] & ~(clr_we_i & bits_i[i]));
        if (en_we_i && bits_i[i])       mask_q[i] <= 1'b0;
        else if (dis_we_i && bits_i[i]) mask_q[i] <= 1'b1;
      end
    end

    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> sts_q[i]);
    assert_unmask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_we_i && bits_i[i] |=> !mask_q[i]);
    assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dis_we_i && bits_i[i] && !en_we_i |=> mask_q[i]);
  end

  assign irq_o  = |(sts_q & ~mask_q);
  assign sts_o  = sts_q;
  assign mask_o = mask_q;

  assert_masked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CAL_W  = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              wr;
  logic              unused_addr;
  logic [DATA_W-1:0] time_now, time_rb, alarm_q, ctrl_q;
  logic [CAL_W-1:0]  cal_q;
  logic [NSRC-1:0]   ev_set, sts, mask;
  logic              alm_evt;

  assign widx        = addr_i[ADDR_W-1:2];
  assign unused_addr = ^addr_i[1:0];
  assign wr          = req_i & we_i;

  function automatic logic hit(input logic [WIDX_W-1:0] w, input int unsigned ofs);
    return w == WIDX_W'(ofs);
  endfunction

  rtc_time_keeper #(.TIME_W(DATA_W)) u_time (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (sec_tick_i),
    .set_we_i  (wr && hit(widx, OFS_TSET)),
    .set_val_i (wdata_i),
    .time_o    (time_now),
    .set_rb_o  (time_rb)
  );

  rtc_alarm_match #(.TIME_W(DATA_W)) u_alarm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .time_i  (time_now),
    .alarm_i (alarm_q),
    .evt_o   (alm_evt)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[SRC_SEC] = sec_tick_i;
    ev_set[SRC_ALM] = alm_evt;
  end

  rtc_irq_ctrl #(.NSRC(NSRC)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (ev_set),
    .clr_we_i (wr && hit(widx, OFS_IST)),
    .en_we_i  (wr && hit(widx, OFS_IEN)),
    .dis_we_i (wr && hit(widx, OFS_IDIS)),
    .bits_i   (wdata_i[NSRC-1:0]),
    .sts_o    (sts),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
      ctrl_q  <= '0;
      cal_q   <= '0;
    end else if (wr) begin
      if (hit(widx, OFS_ALARM))  alarm_q <= wdata_i;
      if (hit(widx, OFS_CTRL))   ctrl_q  <= wdata_i & CTRL_KEEP;
      if (hit(widx, OFS_CAL_WR)) cal_q   <= wdata_i[CAL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if      (hit(widx, OFS_TSET_RB)) rdata_o = time_rb;
    else if (hit(widx, OFS_CAL_RD))  rdata_o = DATA_W'(cal_q);
    else if (hit(widx, OFS_TNOW))    rdata_o = time_now;
    else if (hit(widx, OFS_ALARM))   rdata_o = alarm_q;
    else if (hit(widx, OFS_IST))     rdata_o = DATA_W'(sts);
    else if (hit(widx, OFS_IMSK))    rdata_o = DATA_W'(mask);
    else if (hit(widx, OFS_CTRL))    rdata_o = ctrl_q;
  end

  assert_ctrl_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && hit(widx, OFS_CTRL) |=> (ctrl_q & ~CTRL_KEEP) == '0);
endmodule

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;
  typedef enum logic [1:0] {K_WR = 2'd0, K_RD = 2'd1, K_TK = 2'd2} kind_e;
  typedef struct packed {
    kind_e       kind;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{K_WR, 8'h00, 32'd100,        4'd4},
    '{K_RD, 8'h04, 32'd100,        4'd4},   // R4 readback at once
    '{K_RD, 8'h10, 32'd0,          4'd4},   // R4 not loaded yet
    '{K_TK, 8'h00, 32'd0,          4'd0},
    '{K_RD, 8'h10, 32'd100,        4'd4},   // R4 loaded exactly
    '{K_RD, 8'h20, 32'd1,          4'd3},   // R3 seconds event
    '{K_TK, 8'h00, 32'd0,          4'd0},
    '{K_RD, 8'h10, 32'd101,        4'd2},   // R2 increment
    '{K_WR, 8'h18, 32'd103,        4'd6},
    '{K_RD, 8'h18, 32'd103,        4'd6},
    '{K_TK, 8'h00, 32'd0,          4'd0},
    '{K_RD, 8'h20, 32'd1,          4'd6},   // R6 no alarm at 102
    '{K_TK, 8'h00, 32'd0,          4'd0},
    '{K_RD, 8'h20, 32'd3,          4'd6},   // R6 alarm at 103
    '{K_WR, 8'h20, 32'd1,          4'd7},
    '{K_RD, 8'h20, 32'd2,          4'd7},   // R7 only bit0 cleared
    '{K_RD, 8'h24, 32'd3,          4'd8},
    '{K_WR, 8'h28, 32'd2,          4'd8},
    '{K_RD, 8'h24, 32'd1,          4'd8},   // R8 unmask alarm
    '{K_WR, 8'h2C, 32'hFFFF_FFFF,  4'd8},
    '{K_RD, 8'h24, 32'd3,          4'd8},   // R8 mask, high bits ignored
    '{K_WR, 8'h40, 32'hFFFF_FFFF,  4'd10},
    '{K_RD, 8'h40, 32'h8100_0000,  4'd10},  // R10
    '{K_WR, 8'h08, 32'hFFFF_FFFF,  4'd11},
    '{K_RD, 8'h0C, 32'h001F_FFFF,  4'd11},  // R11
    '{K_RD, 8'h08, 32'd0,          4'd11},
    '{K_RD, 8'h14, 32'd0,          4'd11},
    '{K_RD, 8'h3C, 32'd0,          4'd11}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(sec), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec = 1'b1;
    @(negedge clk); sec = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h10, 32'd0, "R1 time");
    rd(8'h04, 32'd0, "R1 readback");
    rd(8'h20, 32'd0, "R1 status");
    rd(8'h24, 32'd3, "R1 mask");
    chk("R1 irq", {31'd0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        K_WR:    wr(VEC[i].addr, VEC[i].data);
        K_TK:    tick();
        default: rd(VEC[i].addr, VEC[i].data, $sformatf("R%0d vec %0d", VEC[i].req, i));
      endcase
    end

    // R2 wrap
    wr(8'h00, 32'hFFFF_FFFE);
    tick();
    rd(8'h10, 32'hFFFF_FFFE, "R4 load before wrap");
    tick();
    rd(8'h10, 32'hFFFF_FFFF, "R2 max");
    tick();
    rd(8'h10, 32'd0, "R2 wrap to zero");

    // R5 write in strobe cycle
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 8'h00; wdata = 32'd500; sec = 1'b1;
    @(negedge clk); req = 1'b0; we = 1'b0; sec = 1'b0;
    rd(8'h10, 32'd1, "R5 strobe used old state");
    rd(8'h04, 32'd500, "R5 readback");
    tick();
    rd(8'h10, 32'd500, "R5 loaded at next strobe");

    // R7 event beats clear
    wr(8'h20, 32'd3);
    rd(8'h20, 32'd0, "R7 clear all");
    @(negedge clk); req = 1'b1; we = 1'b1; addr = 8'h20; wdata = 32'd1; sec = 1'b1;
    @(negedge clk); req = 1'b0; we = 1'b0; sec = 1'b0;
    rd(8'h20, 32'd1, "R7 set wins");

    // R6 alarm written equal to current time (501)
    wr(8'h20, 32'd3);
    wr(8'h18, 32'd501);
    rd(8'h20, 32'd2, "R6 alarm by write");
    rd(8'h20, 32'd2, "R6 held once");

    // R9 gating
    chk("R9 masked", {31'd0, irq}, 32'd0);
    wr(8'h28, 32'd1);
    chk("R9 unmasked idle source", {31'd0, irq}, 32'd0);
    wr(8'h28, 32'd2);
    chk("R9 unmasked pending", {31'd0, irq}, 32'd1);
    wr(8'h2C, 32'd2);
    chk("R9 remasked", {31'd0, irq}, 32'd0);
    rd(8'h20, 32'd2, "R9 status kept while masked");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule